// File: doc/BRIEF.md
# UTMI Data Width Adapter (8-bit / 16-bit)

This block sits between a serial interface engine and a transceiver core that moves one byte at a time. A static mode input picks one of two data paths. In narrow mode the engine sees an 8-bit unidirectional path: transmit bytes enter on the low lane of the bus, and receive bytes leave on the high lane. In wide mode the engine sees a 16-bit bidirectional bus that runs at half the byte rate. The half-rate interface clock is modelled as a clock enable, `if_ce`, on the byte clock. In this mode the adapter splits each transmit word into bytes for the core, and packs received bytes into words for the engine.

A single high-byte qualifier travels with the wide bus and changes direction along with it. On transmit the engine drives the qualifier low to send only the low byte of a word. On receive the adapter drives it low on the final word of a packet that has an odd number of bytes. The tristate bus is modelled as separate input and output vectors plus drive enables. Enable lane 0 covers bits [7:0] and lane 1 covers bits [15:8].

Both stream interfaces follow valid/ready rules. On transmit, the engine holds `tx_valid` and the word steady until `tx_ready` is high on an interface edge. The core pulls bytes with `core_tx_ready` and may stall on any cycle. On receive there is no back-pressure toward the core, which may deliver at most one byte per byte clock. The adapter double-buffers, so a word completes no faster than the engine edges arrive. A completed word waits only while `tx_valid` is high.

Top module: `utmi_width_adapter`

## Requirements
- R1: In narrow mode (`wide_mode`=0), `core_tx_valid` equals `tx_valid`, `core_tx_data` equals `bus_in[7:0]`, and `tx_ready` equals `core_tx_ready`, all in the same cycle.
- R2: In narrow mode, `rx_valid` equals `core_rx_valid` and `rx_active` equals `core_rx_active`. `bus_out[15:8]` carries `core_rx_data` while `core_rx_valid` is 1 and is zero otherwise. `bus_out[7:0]` is always zero.
- R3: In narrow mode, `bus_oe` is 2'b10 (only the high lane drives), and both `hi_oe` and `hi_out` are 0.
- R4: In wide mode, each transmit word reaches the core as `bus_in[7:0]` followed by `bus_in[15:8]` when `hi_in`=1, or as `bus_in[7:0]` alone when `hi_in`=0. Words go out in the order they were presented.
- R5: In wide mode, `tx_ready` is high for exactly one cycle per word. That cycle has `if_ce`=1 and comes after the core has accepted every byte of the word.
- R6: In wide mode, a cycle with `tx_valid`=0 abandons any partly sent word, so the next word starts with its low byte.
- R7: In wide mode, received bytes pair up in arrival order: the first byte goes to `bus_out[7:0]`, the second to `bus_out[15:8]`, and `hi_out`=1.
- R8: In wide mode, when `core_rx_active` falls after an odd number of bytes, the last byte is delivered in `bus_out[7:0]` with `bus_out[15:8]`=0 and `hi_out`=0.
- R9: In wide mode, each packed word is presented with `rx_valid`=1 exactly once, on a cycle with `if_ce`=1 and `tx_valid`=0. Until then the word is held.
- R10: In wide mode, `rx_active` stays 1 from the first byte of a packet until its last word has been delivered, and drops afterwards.
- R11: In wide mode, `bus_oe`=2'b11 and `hi_oe`=1 exactly in the cycles with `tx_valid`=0 and `rx_valid`=1. In all other cycles both enables are 0 and `bus_out` is zero.
- R12: While `rst` is high, and after it falls, `tx_ready`, `rx_valid`, `rx_active` (with the core idle) and both drive enables in wide mode are 0. Any partial word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 0: 8-bit path, 1: 16-bit path (static outside reset) |
| if_ce | input | 1 | Interface-clock enable used in wide mode |
| tx_valid | input | 1 | Engine transmit valid |
| tx_ready | output | 1 | Word (or byte) taken, next may be presented |
| bus_in | input | 16 | Bus value driven by the engine |
| bus_out | output | 16 | Bus value driven by the adapter |
| bus_oe | output | 2 | Drive enable per byte lane (bit 0: [7:0], bit 1: [15:8]) |
| hi_in | input | 1 | High-byte qualifier from the engine |
| hi_out | output | 1 | High-byte qualifier from the adapter |
| hi_oe | output | 1 | Drive enable of the qualifier |
| rx_valid | output | 1 | Receive data on the bus is valid |
| rx_active | output | 1 | Receive packet in progress |
| core_tx_valid | output | 1 | Byte offered to the core |
| core_tx_data | output | 8 | Byte offered to the core |
| core_tx_ready | input | 1 | Core accepts the offered byte |
| core_rx_valid | input | 1 | Core delivers a received byte |
| core_rx_data | input | 8 | Received byte |
| core_rx_active | input | 1 | Core receive packet active |

## Verification
A transmit phase bit that is stuck or slow shows up as a repeated or missing byte at `core_tx_data`. The error appears on the next accepted byte, and `tx_ready` then arrives after the wrong number of bytes for that word. A fault in the receive packer swaps or duplicates lanes, or sends a wrong qualifier, on the first word delivered on an interface edge, which is at most two cycles after the pair completes. A lost odd byte appears at the packet end as a missing word and as `rx_active` dropping early. Direction faults show within a single cycle as drive enables that disagree with `tx_valid` and `rx_valid`.

// File: rtl/utmi_wa_pkg.sv
package utmi_wa_pkg;
  typedef enum logic {
    TXP_LOW  = 1'b0,
    TXP_HIGH = 1'b1
  } tx_phase_e;

  localparam int LANE_CNT = 2;
endpackage

// File: rtl/utmi_wa_tx.sv
module utmi_wa_tx
  import utmi_wa_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W * LANE_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              if_ce,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic              hi_in,
  input  logic              core_ready,
  output logic              core_valid,
  output logic [BYTE_W-1:0] core_data,
  output logic              word_done
);
  tx_phase_e phase_q;
  logic      pend_q;
  logic      take;
  logic      last_byte;

  // Offer a byte only while a word is in flight and not yet acknowledged.
  assign core_valid = tx_valid & ~pend_q;
  assign core_data  = (phase_q == TXP_HIGH) ? word_in[WORD_W-1 -: BYTE_W]
                                            : word_in[BYTE_W-1:0];
  assign take       = core_valid & core_ready;
  assign last_byte  = take & ((phase_q == TXP_HIGH) | ~hi_in);
  assign word_done  = pend_q & if_ce;

  always_ff @(posedge clk) begin
    if (rst || !en || !tx_valid) begin
      phase_q <= TXP_LOW;
      pend_q  <= 1'b0;
    end else if (word_done) begin
      pend_q  <= 1'b0;
    end else if (last_byte) begin
      pend_q  <= 1'b1;
      phase_q <= TXP_LOW;
    end else if (take) begin
      phase_q <= TXP_HIGH;
    end
  end
endmodule

// File: rtl/utmi_wa_rx.sv
module utmi_wa_rx
  import utmi_wa_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W * LANE_CNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              if_ce,
  input  logic              hold,
  input  logic              core_valid,
  input  logic [BYTE_W-1:0] core_data,
  input  logic              core_active,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              word_hi,
  output logic              pkt_active
);
  logic [BYTE_W-1:0] low_q;
  logic              have_low_q;
  logic [WORD_W-1:0] out_q;
  logic              out_hi_q;
  logic              out_full_q;
  logic              byte_in;
  logic              pair_done;
  logic              odd_flush;
  logic              deliver;

  assign byte_in    = core_valid & core_active;
  assign pair_done  = byte_in & have_low_q;
  assign odd_flush  = have_low_q & ~core_active;
  assign deliver    = out_full_q & if_ce & ~hold;

  assign word_valid = deliver;
  assign word_data  = out_q;
  assign word_hi    = out_hi_q;
  assign pkt_active = core_active | have_low_q | out_full_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      low_q      <= '0;
      have_low_q <= 1'b0;
      out_q      <= '0;
      out_hi_q   <= 1'b0;
      out_full_q <= 1'b0;
    end else begin
      if (pair_done) begin
        out_q      <= {core_data, low_q};
        out_hi_q   <= 1'b1;
        out_full_q <= 1'b1;
        have_low_q <= 1'b0;
      end else if (odd_flush) begin
        out_q      <= {{(WORD_W-BYTE_W){1'b0}}, low_q};
        out_hi_q   <= 1'b0;
        out_full_q <= 1'b1;
        have_low_q <= 1'b0;
      end else begin
        if (deliver) out_full_q <= 1'b0;
        if (byte_in) begin
          low_q      <= core_data;
          have_low_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/utmi_wa_dir.sv
module utmi_wa_dir
  import utmi_wa_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W * LANE_CNT
) (
  input  logic                wide,
  input  logic                tx_valid,
  input  logic                w_valid,
  input  logic [WORD_W-1:0]   w_data,
  input  logic                w_hi,
  input  logic                n_rx_valid,
  input  logic [BYTE_W-1:0]   n_rx_data,
  output logic [WORD_W-1:0]   bus_out,
  output logic [LANE_CNT-1:0] bus_oe,
  output logic                hi_out,
  output logic                hi_oe
);
  logic drive;

  assign drive  = wide & ~tx_valid & w_valid;
  assign hi_oe  = drive;
  assign hi_out = drive & w_hi;

  for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
    localparam bit TOP_LANE = (l == LANE_CNT - 1);
    assign bus_oe[l] = wide ? drive : TOP_LANE;
    assign bus_out[l*BYTE_W +: BYTE_W] =
      wide ? (drive ? w_data[l*BYTE_W +: BYTE_W] : '0)
           : ((TOP_LANE && n_rx_valid) ? n_rx_data : '0);
  end
endmodule

// File: rtl/utmi_width_adapter.sv
module utmi_width_adapter
  import utmi_wa_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = BYTE_W * LANE_CNT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide_mode,
  input  logic                if_ce,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [WORD_W-1:0]   bus_in,
  output logic [WORD_W-1:0]   bus_out,
  output logic [LANE_CNT-1:0] bus_oe,
  input  logic                hi_in,
  output logic                hi_out,
  output logic                hi_oe,
  output logic                rx_valid,
  output logic                rx_active,
  output logic                core_tx_valid,
  output logic [BYTE_W-1:0]   core_tx_data,
  input  logic                core_tx_ready,
  input  logic                core_rx_valid,
  input  logic [BYTE_W-1:0]   core_rx_data,
  input  logic                core_rx_active
);
  logic              w_core_valid;
  logic [BYTE_W-1:0] w_core_data;
  logic              w_word_done;
  logic              w_rx_valid;
  logic [WORD_W-1:0] w_rx_data;
  logic              w_rx_hi;
  logic              w_rx_active;

  utmi_wa_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .en         (wide_mode),
    .if_ce      (if_ce),
    .tx_valid   (tx_valid),
    .word_in    (bus_in),
    .hi_in      (hi_in),
    .core_ready (core_tx_ready),
    .core_valid (w_core_valid),
    .core_data  (w_core_data),
    .word_done  (w_word_done)
  );

  utmi_wa_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .en          (wide_mode),
    .if_ce       (if_ce),
    .hold        (tx_valid),
    .core_valid  (core_rx_valid),
    .core_data   (core_rx_data),
    .core_active (core_rx_active),
    .word_valid  (w_rx_valid),
    .word_data   (w_rx_data),
    .word_hi     (w_rx_hi),
    .pkt_active  (w_rx_active)
  );

  utmi_wa_dir #(.BYTE_W(BYTE_W)) u_dir (
    .wide       (wide_mode),
    .tx_valid   (tx_valid),
    .w_valid    (w_rx_valid),
    .w_data     (w_rx_data),
    .w_hi       (w_rx_hi),
    .n_rx_valid (core_rx_valid),
    .n_rx_data  (core_rx_data),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .hi_out     (hi_out),
    .hi_oe      (hi_oe)
  );

  // Narrow mode is a straight pass-through; wide mode uses the converters.
  assign core_tx_valid = wide_mode ? w_core_valid : tx_valid;
  assign core_tx_data  = wide_mode ? w_core_data  : bus_in[BYTE_W-1:0];
  assign tx_ready      = wide_mode ? w_word_done  : core_tx_ready;
  assign rx_valid      = wide_mode ? w_rx_valid   : core_rx_valid;
  assign rx_active     = wide_mode ? w_rx_active  : core_rx_active;
endmodule

// File: rtl/utmi_wa_chk.sv
module utmi_wa_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wide_mode,
  input logic                if_ce,
  input logic                tx_valid,
  input logic                tx_ready,
  input logic [2*BYTE_W-1:0] bus_out,
  input logic [1:0]          bus_oe,
  input logic                hi_out,
  input logic                hi_oe,
  input logic                rx_valid,
  input logic                rx_active,
  input logic                core_tx_valid
);
  // R5: acknowledgement only on an interface edge
  a_r5_ready_on_edge: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && tx_ready) |-> if_ce);
  // R5: one acknowledgement per word, never two in a row
  a_r5_ready_single: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && tx_ready) |=> !tx_ready);
  // R5: no byte offered to the core while the word is being acknowledged
  a_r5_no_byte_at_ack: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && tx_ready) |-> !core_tx_valid);
  // R9: words presented only on interface edges and not during transmit
  a_r9_rx_on_edge: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && rx_valid) |-> (if_ce && !tx_valid));
  // R10: a delivered word always lies inside an active packet
  a_r10_active_covers: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && rx_valid) |-> rx_active);
  // R11: the engine owns the bus while it transmits
  a_r11_tx_owns_bus: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && tx_valid) |-> (bus_oe == 2'b00 && !hi_oe));
  // R8: a single-byte word carries a zero upper lane
  a_r8_odd_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && rx_valid && !hi_out) |-> (bus_out[2*BYTE_W-1:BYTE_W] == '0));
  // R3: narrow mode never drives the qualifier or the low lane
  a_r3_narrow_dir: assert property (@(posedge clk) disable iff (rst)
    !wide_mode |-> (!hi_oe && !bus_oe[0]));
endmodule

bind utmi_width_adapter utmi_wa_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wide_mode     (wide_mode),
  .if_ce         (if_ce),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .bus_out       (bus_out),
  .bus_oe        (bus_oe),
  .hi_out        (hi_out),
  .hi_oe         (hi_oe),
  .rx_valid      (rx_valid),
  .rx_active     (rx_active),
  .core_tx_valid (core_tx_valid)
);

// File: tb/utmi_width_adapter_tb.sv
module utmi_width_adapter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_mode = 1'b0;
  logic        if_ce = 1'b1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out;
  logic [1:0]  bus_oe;
  logic        hi_in = 1'b0;
  logic        hi_out;
  logic        hi_oe;
  logic        rx_valid;
  logic        rx_active;
  logic        core_tx_valid;
  logic [7:0]  core_tx_data;
  logic        core_tx_ready = 1'b0;
  logic        core_rx_valid = 1'b0;
  logic [7:0]  core_rx_data = '0;
  logic        core_rx_active = 1'b0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  utmi_width_adapter u_dut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .if_ce(if_ce),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .hi_in(hi_in), .hi_out(hi_out),
    .hi_oe(hi_oe), .rx_valid(rx_valid), .rx_active(rx_active),
    .core_tx_valid(core_tx_valid), .core_tx_data(core_tx_data),
    .core_tx_ready(core_tx_ready), .core_rx_valid(core_rx_valid),
    .core_rx_data(core_rx_data), .core_rx_active(core_rx_active)
  );

  typedef struct packed {
    logic       txv;  logic [7:0] lo;  logic crdy;
    logic       rxv;  logic [7:0] rxd; logic rxa;
    logic       e_ctxv; logic [7:0] e_ctxd; logic e_txr;
    logic       e_rxv;  logic [15:0] e_bus; logic e_rxa;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t TBL [NVEC] = '{
    {1'b1, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 16'h0000, 1'b0},
    {1'b1, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 16'h0000, 1'b1},
    {1'b0, 8'h77, 1'b1, 1'b1, 8'h9E, 1'b1, 1'b0, 8'h77, 1'b1, 1'b1, 16'h9E00, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h5B, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 16'h0000, 1'b1},
    {1'b1, 8'hFF, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 16'hC300, 1'b1},
    {1'b0, 8'h12, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 8'h12, 1'b0, 1'b1, 16'h0100, 1'b0}
  };

  logic [15:0] tw [4];
  logic        th [4];
  logic [15:0] gw [8];
  logic        gh [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance to the next falling edge; in wide mode the interface enable alternates.
  task automatic tick();
    @(negedge clk);
    if (wide_mode) if_ce = ~if_ce;
    else if_ce = 1'b1;
  endtask

  task automatic do_reset(input logic wide);
    rst = 1'b1; wide_mode = wide;
    tx_valid = 0; core_tx_ready = 0; core_rx_valid = 0; core_rx_active = 0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic run_tx(input int n, input int stall_mod);
    logic [7:0] eb [16];
    logic [7:0] got [16];
    int cum [4];
    int ne = 0, wi = 0, nb = 0, cyc = 0;
    for (int w = 0; w < n; w++) begin
      eb[ne] = tw[w][7:0]; ne++;
      if (th[w]) begin eb[ne] = tw[w][15:8]; ne++; end
      cum[w] = ne;
    end
    while (wi < n && cyc < 80) begin
      tick();
      tx_valid = 1'b1; bus_in = tw[wi]; hi_in = th[wi];
      core_tx_ready = (stall_mod == 0) || (cyc % stall_mod != 0);
      #1;
      if (core_tx_valid && core_tx_ready) begin
        if (nb < 16) got[nb] = core_tx_data;
        nb++;
      end
      if (tx_ready) begin
        chk("R5 tx_ready on interface edge", 32'(if_ce), 32'd1);
        chk("R5 bytes taken before tx_ready", nb, cum[wi]);
        wi++;
      end
      cyc++;
    end
    tick();
    tx_valid = 1'b0; core_tx_ready = 1'b0;
    chk("R5 one tx_ready per word", wi, n);
    chk("R4 byte count", nb, ne);
    for (int b = 0; b < ne && b < 16; b++) chk("R4 byte order", 32'(got[b]), 32'(eb[b]));
  endtask

  task automatic run_rx(input int n, input int stride, input logic [7:0] base);
    int nw = 0;
    int total = n * stride + 10;
    for (int c = 0; c < total; c++) begin
      tick();
      if (c < n * stride) begin
        core_rx_active = 1'b1;
        core_rx_valid  = (c % stride == 0);
        core_rx_data   = base + 8'(c / stride);
      end else begin
        core_rx_active = 1'b0; core_rx_valid = 1'b0;
      end
      #1;
      if (rx_valid) begin
        chk("R9 rx_valid on interface edge", 32'(if_ce), 32'd1);
        chk("R11 drive enables while delivering", {bus_oe, hi_oe}, 3'b111);
        chk("R10 rx_active at delivery", 32'(rx_active), 32'd1);
        if (nw < 8) begin gw[nw] = bus_out; gh[nw] = hi_out; end
        nw++;
      end else begin
        chk("R11 idle bus", {bus_oe, hi_oe, bus_out}, 0);
      end
    end
    chk("R9 word count", nw, (n + 1) / 2);
    for (int w = 0; w < (n + 1) / 2 && w < 8; w++) begin
      if (2 * w + 1 < n) begin
        chk("R7 packed word", 32'(gw[w]), 32'({base + 8'(2*w+1), base + 8'(2*w)}));
        chk("R7 qualifier high", 32'(gh[w]), 32'd1);
      end else begin
        chk("R8 odd last word", 32'(gw[w]), 32'({8'h00, base + 8'(2*w)}));
        chk("R8 qualifier low", 32'(gh[w]), 32'd0);
      end
    end
    chk("R10 rx_active dropped", 32'(rx_active), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R12: reset state in wide mode
    wide_mode = 1'b1;
    repeat (2) tick();
    #1;
    chk("R12 in reset", {tx_ready, rx_valid, rx_active, bus_oe, hi_oe}, 0);
    do_reset(1'b1);
    #1;
    chk("R12 after reset", {tx_ready, rx_valid, rx_active, bus_oe, hi_oe}, 0);

    // R1 R2 R3: narrow-mode table
    do_reset(1'b0);
    for (int i = 0; i < NVEC; i++) begin
      tick();
      tx_valid = TBL[i].txv; bus_in = {8'hEE, TBL[i].lo};
      core_tx_ready = TBL[i].crdy; core_rx_valid = TBL[i].rxv;
      core_rx_data = TBL[i].rxd; core_rx_active = TBL[i].rxa;
      #1;
      chk("R1 narrow transmit", {core_tx_valid, core_tx_data, tx_ready},
          {TBL[i].e_ctxv, TBL[i].e_ctxd, TBL[i].e_txr});
      chk("R2 narrow receive", {rx_valid, bus_out, rx_active},
          {TBL[i].e_rxv, TBL[i].e_bus, TBL[i].e_rxa});
      chk("R3 narrow direction", {bus_oe, hi_oe, hi_out}, 4'b1000);
    end

    // R4 R5: wide transmit, with and without core stalls
    tw[0] = 16'hA1B2; th[0] = 1'b1;
    tw[1] = 16'h0C3D; th[1] = 1'b0;
    tw[2] = 16'h5E6F; th[2] = 1'b1;
    tw[3] = 16'h9988; th[3] = 1'b0;
    do_reset(1'b1);
    run_tx(4, 0);
    do_reset(1'b1);
    run_tx(4, 3);

    // R6: abandoned word restarts with its low byte
    do_reset(1'b1);
    tick();
    tx_valid = 1'b1; bus_in = 16'hC0DE; hi_in = 1'b1; core_tx_ready = 1'b1;
    #1;
    chk("R6 first byte", 32'(core_tx_data), 32'h00DE);
    tick();
    #1;
    chk("R6 second byte pending", 32'(core_tx_data), 32'h00C0);
    tx_valid = 1'b0;
    #1;
    chk("R6 nothing offered when tx_valid low", 32'(core_tx_valid), 32'd0);
    tick();
    tx_valid = 1'b1; bus_in = 16'h1234;
    #1;
    chk("R6 restart with low byte", {core_tx_valid, core_tx_data}, {1'b1, 8'h34});
    tick();
    tx_valid = 1'b0; core_tx_ready = 1'b0;

    // R7 R8 R9 R10 R11: wide receive, odd and even, back-to-back and spaced
    do_reset(1'b1);
    run_rx(5, 1, 8'h11);
    run_rx(4, 2, 8'h40);
    run_rx(1, 1, 8'h7A);

    // R9 R11: a finished word waits while the engine transmits
    do_reset(1'b1);
    for (int c = 0; c < 8; c++) begin
      tick();
      tx_valid = 1'b1; core_tx_ready = 1'b0; bus_in = 16'h0;
      core_rx_active = (c < 2); core_rx_valid = (c < 2);
      core_rx_data = 8'hB0 + 8'(c);
      #1;
      if (c >= 2) begin
        chk("R9 held during transmit", {rx_valid, bus_oe, hi_oe}, 0);
        chk("R10 active while word held", 32'(rx_active), 32'd1);
      end
    end
    begin
      int seen = 0;
      for (int c = 0; c < 4; c++) begin
        tick();
        tx_valid = 1'b0;
        #1;
        if (rx_valid) begin
          seen++;
          chk("R7 held word content", {bus_out, hi_out}, {16'hB1B0, 1'b1});
        end
      end
      chk("R9 held word delivered once", seen, 1);
    end

    // R12: reset in the middle of a packet discards the half word
    do_reset(1'b1);
    tick();
    core_rx_active = 1'b1; core_rx_valid = 1'b1; core_rx_data = 8'h99;
    tick();
    core_rx_valid = 1'b0;
    rst = 1'b1; core_rx_active = 1'b0;
    tick();
    rst = 1'b0;
    begin
      int seen = 0;
      for (int c = 0; c < 5; c++) begin
        tick();
        #1;
        if (rx_valid || rx_active) seen++;
      end
      chk("R12 partial word discarded", seen, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule